// File: doc/BRIEF.md
# Coprime Search Engine

This multi-cycle engine takes a nonzero 16-bit value `n`. It returns the smallest integer `m`, counting up from 2, that shares no common factor with `n` other than one. Each candidate is tested with the subtraction form of Euclid's method. The engine does one subtraction per clock. When a test gives a greatest common divisor above one, the candidate goes up by one and the next test begins.

A caller starts the engine by pulsing `start` for one cycle, with the operand on `n_in`, while the engine is idle. `busy` stays high for the whole search. `done` pulses once when the answer is written to `m_out`. The answer stays on `m_out` until a later search finishes. The caller must never present zero as the operand.

Top module: `relprime_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy` and `done` are 0 and `m_out` is 0.
- R2: A `start` pulse seen while `busy` is 0 captures `n_in`, and `busy` is 1 from the next cycle on.
- R3: On completion, `m_out` holds the smallest m >= 2 for which gcd(n, m) = 1.
- R4: The first candidate tried is 2, so every odd `n` gives the result 2.
- R5: `done` is high for exactly one cycle. `busy` is 1 in that cycle and 0 in the cycle after it.
- R6: `m_out` changes only in the cycle where `done` is high. It keeps its value while idle.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored. Neither the operand nor the result of the search in progress changes.
- R8: Each gcd test runs subtraction steps until one operand is zero. The nonzero operand is then the gcd. The result is correct even when a test needs thousands of steps, as with `n` = 65535 or 65534.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| n_in | input | 16 | Operand, sampled with `start`; must be nonzero |
| busy | output | 1 | High while a search is in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| m_out | output | 16 | Smallest coprime value found |

## Verification
The assertions assume that `n_in` is never zero when a start is accepted. They also assume that `start` is a pulse from a caller that waits for `done` before issuing the next request. Only the stray start of the R7 test breaks that rule. The bench keeps within these limits: it only ever drives operands from 1 upward. It sweeps every operand from 1 to 200, then the costly values 65535 and 65534 and a product of small primes, and compares each result with a modulo-based gcd search computed in the bench.

// File: rtl/relprime_engine.sv
module relprime_engine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] n_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] m_out
);
  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_STEP, S_CHECK, S_DONE} st_t;

  st_t         st;
  logic [W-1:0] n_q, m_q, a, b, g;
  logic         stop;

  assign stop = (a == '0) || (b == '0);
  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      n_q   <= '0;
      m_q   <= '0;
      a     <= '0;
      b     <= '0;
      g     <= '0;
      m_out <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          n_q <= n_in;
          m_q <= W'(2);
          st  <= S_LOAD;
        end
        S_LOAD: begin
          a  <= n_q;
          b  <= m_q;
          st <= S_STEP;
        end
        S_STEP: begin
          if (stop) begin
            g  <= (a == '0) ? b : a;
            st <= S_CHECK;
          end else if (a > b) begin
            a <= a - b;
          end else begin
            b <= b - a;
          end
        end
        S_CHECK: begin
          if (g == W'(1)) begin
            m_out <= m_q;
            st    <= S_DONE;
          end else begin
            m_q <= m_q + W'(1);
            st  <= S_LOAD;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/relprime_engine_chk.sv
module relprime_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] m_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!busy && !done && m_out == '0)
        else $error("reset state not quiet");
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  p_result_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (m_out >= W'(2)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  p_idle_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(m_out) |-> done);
endmodule

bind relprime_engine relprime_engine_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .m_out(m_out)
);

// File: tb/test_relprime_engine.sv
module test_relprime_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] n_in = '0;
  logic        busy, done;
  logic [15:0] m_out;
  int total = 0;
  int bad = 0;
  int cyc = 0;
  localparam int LIMIT = 190000;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  relprime_engine i_relprime_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .busy(busy), .done(done), .m_out(m_out)
  );

  function automatic int gcd_ref(int x, int y);
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int coprime_ref(int n);
    int m = 2;
    while (gcd_ref(n, m) != 1) m++;
    return m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic kick(int n);
    @(negedge clk);
    start = 1'b1;
    n_in  = 16'(n);
    @(negedge clk);
    start = 1'b0;
    n_in  = '0;
  endtask

  task automatic wait_done();
    while (!done) begin
      if (cyc > LIMIT) begin
        chk(1'b0, "watchdog", cyc, LIMIT);
        finish_run();
      end
      @(negedge clk);
    end
  endtask

  task automatic run(int n, string req);
    int exp = coprime_ref(n);
    kick(n);
    chk(busy == 1'b1, "R2", busy, 1);
    wait_done();
    chk(m_out == 16'(exp), req, m_out, exp);
    @(negedge clk);
    chk(!done && !busy, "R5", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && m_out == 0, "R1", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && m_out == 0, "R1", m_out, 0);

    for (int n = 1; n <= 200; n++) begin
      if (n % 2 == 1) run(n, "R4");
      else run(n, "R3");
    end

    run(65535, "R8");
    run(65534, "R8");
    run(510, "R3");

    kick(6);
    repeat (3) @(negedge clk);
    start = 1'b1;
    n_in  = 16'd1;
    @(negedge clk);
    start = 1'b0;
    n_in  = '0;
    wait_done();
    chk(m_out == 16'd5, "R7", m_out, 5);
    @(negedge clk);
    chk(!done, "R5", done, 0);

    repeat (20) @(negedge clk);
    chk(m_out == 16'd5 && !busy, "R6", m_out, 5);

    finish_run();
  end
endmodule